// File: doc/BRIEF.md
# Packet-Atomic Readback FIFO

This block buffers readback data on its way from an internal producer to a register bus. The producer offers a packet of four 32-bit words at a time on a valid/ready port. The block admits the packet only if four entries are free at that moment. An admitted packet is written into storage over the next four cycles, lowest word first. A packet that does not fit is thrown away in full, and a sticky overflow flag records the loss. A packet is therefore never split across the FIFO boundary.

The bus side sees a single read window. Each read strobe returns the oldest word in the same cycle and removes it. A read while the FIFO is empty returns zero and changes nothing. The window does not accept writes: a write strobe leaves the contents untouched and raises a sticky flag of its own. The block also reports the number of words it holds. Reset empties the storage and clears both flags.

Top module: `pkt_readback_fifo`

## Requirements
- R1: After reset the level is 0, `pkt_ready` is 1, both error flags are 0, and a read returns 0.
- R2: An admitted packet is stored in word order. Word 0 is `pkt_data[31:0]` and word 3 is `pkt_data[127:96]`. Later reads return word 0, word 1, word 2, word 3 in that order.
- R3: A packet is admitted at a clock edge where `pkt_valid` and `pkt_ready` are both 1 and at least four entries are free. After that edge `pkt_ready` is 0 for four cycles. During those cycles the level rises by one per cycle. After them `pkt_ready` returns to 1.
- R4: A packet offered while fewer than four entries are free is discarded whole. The level stays the same, `pkt_ready` stays 1, and `err_overflow` becomes 1 after that edge.
- R5: `err_overflow` stays 1 until reset, through reads and later admitted packets.
- R6: While the FIFO is not empty, a cycle with `bus_rd_en` high shows the oldest word on `bus_rd_data` in that same cycle. That word is removed at the clock edge, and the level drops by one.
- R7: A read while the FIFO is empty shows 0 on `bus_rd_data` and leaves the level unchanged.
- R8: A bus write strobe does not change the level or the stored words. It sets the sticky flag `err_bus_write`, which only reset clears.
- R9: When a read removes a word in the same cycle that a packet word is stored, the level stays the same and the order of words is preserved.
- R10: The FIFO holds exactly `DEPTH` words (2048 by default). It accepts a packet when exactly four entries are free. Storage order survives the wrap of the internal pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Producer offers a packet |
| pkt_data | input | 128 | Four packet words, word 0 in the low 32 bits |
| pkt_ready | output | 1 | Loader idle, a packet may be offered |
| bus_rd_en | input | 1 | Read strobe of the bus window |
| bus_rd_data | output | 32 | Word returned for the read in this cycle |
| bus_wr_en | input | 1 | Write strobe of the bus window (ignored) |
| level | output | 12 | Number of words held |
| err_overflow | output | 1 | Sticky: a packet was dropped |
| err_bus_write | output | 1 | Sticky: the window was written |

## Verification
A single packet of four distinct words shows whether the lanes are swapped or the order is reversed. A read issued while a packet is still loading shows whether a store and a pop in the same cycle are counted correctly. Packets are offered with 0, 1 and then exactly 4 entries free, which exposes any off-by-one error in the admission threshold. A full drain of 2048 words runs the pointers through their wrap. Bus writes placed between packets, and reads made on an empty FIFO, show that these accesses leave the contents untouched.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  typedef enum logic {
    LD_IDLE = 1'b0,
    LD_BUSY = 1'b1
  } ld_state_e;

  // Free entries left for a given occupancy.
  function automatic int unsigned slots_free(input int unsigned depth,
                                             input int unsigned held);
    return depth - held;
  endfunction

  // Whole-packet admission test.
  function automatic logic packet_fits(input int unsigned depth,
                                       input int unsigned held,
                                       input int unsigned words);
    return slots_free(depth, held) >= words;
  endfunction

  // Occupancy after one cycle of store and/or pop.
  function automatic int unsigned level_after(input int unsigned held,
                                              input logic store,
                                              input logic take);
    int unsigned n;
    n = held;
    if (store && !take) n = held + 1;
    if (take && !store) n = held - 1;
    return n;
  endfunction

endpackage

// File: rtl/rbf_storage.sv
module rbf_storage #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 2048,
  parameter int unsigned AW     = $clog2(DEPTH),
  parameter int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] head_data,
  output logic [CW-1:0]     level,
  output logic              empty,
  output logic              full
);
  import rbf_pkg::*;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     level_q;

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
      level_q <= CW'(level_after(32'(level_q), push, pop));
    end
  end

  assign head_data = mem_q[rd_ptr_q];
  assign level     = level_q;
  assign empty     = (level_q == '0);
  assign full      = (level_q == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop)); // R4
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R7
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CW'(DEPTH)); // R10
  AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (level_q == $past(level_q) + CW'(1))); // R3
  AST_SAME_CYCLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(level_q)); // R9

endmodule

// File: rtl/rbf_pkt_loader.sv
module rbf_pkt_loader #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned PKT_WORDS = 4,
  parameter int unsigned DEPTH     = 2048,
  parameter int unsigned CW        = $clog2(DEPTH + 1),
  parameter int unsigned IW        = $clog2(PKT_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pkt_valid,
  input  logic [PKT_WORDS*WORD_W-1:0] pkt_data,
  input  logic [CW-1:0]               level,
  output logic                        pkt_ready,
  output logic                        push,
  output logic [WORD_W-1:0]           push_data,
  output logic                        accept_evt,
  output logic                        drop_evt,
  output logic                        err_overflow
);
  import rbf_pkg::*;

  logic [PKT_WORDS-1:0][WORD_W-1:0] pkt_words;
  logic [PKT_WORDS-1:0][WORD_W-1:0] stage_q;
  ld_state_e                        state_q;
  logic [IW-1:0]                    idx_q;
  logic                             ovf_q;
  logic                             has_room;
  logic                             last_word;

  for (genvar g = 0; g < PKT_WORDS; g++) begin : g_unpack
    assign pkt_words[g] = pkt_data[g*WORD_W +: WORD_W];
  end

  always_comb begin
    has_room   = packet_fits(DEPTH, 32'(level), PKT_WORDS);
    accept_evt = pkt_valid && (state_q == LD_IDLE) && has_room;
    drop_evt   = pkt_valid && (state_q == LD_IDLE) && !has_room;
    last_word  = (idx_q == IW'(PKT_WORDS - 1));
  end

  always_ff @(posedge clk) begin
    if (accept_evt) stage_q <= pkt_words;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      idx_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (drop_evt) ovf_q <= 1'b1;
      unique case (state_q)
        LD_IDLE: begin
          if (accept_evt) begin
            state_q <= LD_BUSY;
            idx_q   <= '0;
          end
        end
        LD_BUSY: begin
          if (last_word) begin
            state_q <= LD_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  assign pkt_ready    = (state_q == LD_IDLE);
  assign push         = (state_q == LD_BUSY);
  assign push_data    = stage_q[idx_q];
  assign err_overflow = ovf_q;

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !pkt_ready); // R3
  AST_DROP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (pkt_ready && !push && err_overflow)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow); // R5

endmodule

// File: rtl/rbf_bus_port.sv
module rbf_bus_port #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              empty,
  input  logic [WORD_W-1:0] head_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              pop,
  output logic              err_bus_write
);
  logic wr_err_q;

  assign pop     = rd_en && !empty;
  assign rd_data = pop ? head_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)     wr_err_q <= 1'b0;
    else if (wr_en) wr_err_q <= 1'b1;
  end

  assign err_bus_write = wr_err_q;

  AST_WR_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_bus_write |=> err_bus_write); // R8
  AST_WR_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> err_bus_write); // R8

endmodule

// File: rtl/pkt_readback_fifo.sv
module pkt_readback_fifo #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned PKT_WORDS = 4,
  parameter int unsigned DEPTH     = 2048,
  localparam int unsigned AW       = $clog2(DEPTH),
  localparam int unsigned CW       = $clog2(DEPTH + 1),
  localparam int unsigned PKT_W    = PKT_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic [PKT_W-1:0]  pkt_data,
  output logic              pkt_ready,
  input  logic              bus_rd_en,
  output logic [WORD_W-1:0] bus_rd_data,
  input  logic              bus_wr_en,
  output logic [CW-1:0]     level,
  output logic              err_overflow,
  output logic              err_bus_write
);

  logic              store_we;
  logic [WORD_W-1:0] store_data;
  logic              pop_evt;
  logic [WORD_W-1:0] head_word;
  logic              fifo_empty;
  logic              fifo_full;
  logic              accept_evt;
  logic              drop_evt;

  rbf_pkt_loader #(
    .WORD_W(WORD_W), .PKT_WORDS(PKT_WORDS), .DEPTH(DEPTH), .CW(CW)
  ) u_loader (
    .clk(clk), .rst_n(rst_n),
    .pkt_valid(pkt_valid), .pkt_data(pkt_data), .level(level),
    .pkt_ready(pkt_ready), .push(store_we), .push_data(store_data),
    .accept_evt(accept_evt), .drop_evt(drop_evt),
    .err_overflow(err_overflow)
  );

  rbf_storage #(
    .WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(store_we), .push_data(store_data), .pop(pop_evt),
    .head_data(head_word), .level(level),
    .empty(fifo_empty), .full(fifo_full)
  );

  rbf_bus_port #(.WORD_W(WORD_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .rd_en(bus_rd_en), .wr_en(bus_wr_en),
    .empty(fifo_empty), .head_data(head_word),
    .rd_data(bus_rd_data), .pop(pop_evt),
    .err_bus_write(err_bus_write)
  );

  AST_EXCLUSIVE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({accept_evt, drop_evt, store_we})); // R3
  AST_FULL_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && pkt_valid && pkt_ready) |-> drop_evt); // R10

endmodule

// File: tb/pkt_readback_fifo_tb.sv
`timescale 1ns/1ps
module pkt_readback_fifo_tb;

  localparam int DEPTH = 2048;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pkt_valid = 1'b0;
  logic [127:0] pkt_data = '0;
  logic         pkt_ready;
  logic         bus_rd_en = 1'b0;
  logic [31:0]  bus_rd_data;
  logic         bus_wr_en = 1'b0;
  logic [11:0]  level;
  logic         err_overflow;
  logic         err_bus_write;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;
  logic [31:0] model_q [$];

  always #2 clk = ~clk;

  pkt_readback_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
    .pkt_ready(pkt_ready), .bus_rd_en(bus_rd_en), .bus_rd_data(bus_rd_data),
    .bus_wr_en(bus_wr_en), .level(level), .err_overflow(err_overflow),
    .err_bus_write(err_bus_write)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000 && !done) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=finish", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_q.delete();
    @(negedge clk);
  endtask

  // Read one word; expectation taken from the model.
  task automatic read_expect(input string req);
    logic [31:0] exp, d;
    int pre;
    pre = level;
    exp = (model_q.size() == 0) ? 32'h0 : model_q.pop_front();
    bus_rd_en = 1'b1;
    #1 d = bus_rd_data;
    @(negedge clk);
    bus_rd_en = 1'b0;
    chk(req, d, exp);
    chk(req, 32'(level), (pre == 0) ? 32'd0 : 32'(pre - 1));
  endtask

  task automatic send_pkt(input logic [31:0] w0, w1, w2, w3,
                          input bit accept, input bit step_checks, input string req);
    int pre;
    while (!pkt_ready) @(negedge clk);
    pre = level;
    pkt_data = {w3, w2, w1, w0};
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    if (accept) begin
      if (step_checks) chk({req, " ready low"}, 32'(pkt_ready), 32'd0);
      for (int i = 1; i <= 4; i++) begin
        @(negedge clk);
        if (step_checks) chk({req, " level step"}, 32'(level), 32'(pre + i));
      end
      chk({req, " ready back"}, 32'(pkt_ready), 32'd1);
      model_q.push_back(w0); model_q.push_back(w1);
      model_q.push_back(w2); model_q.push_back(w3);
    end else begin
      chk({req, " level kept"}, 32'(level), 32'(pre));
      chk({req, " ready kept"}, 32'(pkt_ready), 32'd1);
      chk({req, " ovf set"}, 32'(err_overflow), 32'd1);
    end
  endtask

  task automatic t_reset_state();
    chk("R1 level", 32'(level), 32'd0);
    chk("R1 ready", 32'(pkt_ready), 32'd1);
    chk("R1 ovf", 32'(err_overflow), 32'd0);
    chk("R1 wrerr", 32'(err_bus_write), 32'd0);
    read_expect("R1 R7 empty read");
  endtask

  task automatic t_single_packet();
    send_pkt(32'h1111_0000, 32'h2222_0001, 32'h3333_0002, 32'h4444_0003, 1, 1, "R3");
    for (int i = 0; i < 4; i++) read_expect("R2 R6 order");
    read_expect("R7 empty after drain");
  endtask

  task automatic t_bus_write();
    send_pkt(32'hCAFE_0000, 32'hCAFE_0001, 32'hCAFE_0002, 32'hCAFE_0003, 1, 0, "R8 setup");
    bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    chk("R8 level", 32'(level), 32'd4);
    chk("R8 flag", 32'(err_bus_write), 32'd1);
    for (int i = 0; i < 4; i++) read_expect("R8 contents");
    chk("R8 sticky", 32'(err_bus_write), 32'd1);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d, exp;
    send_pkt(32'hA0, 32'hA1, 32'hA2, 32'hA3, 1, 0, "R9 setup");
    while (!pkt_ready) @(negedge clk);
    pkt_data = {32'hB3, 32'hB2, 32'hB1, 32'hB0};
    pkt_valid = 1'b1;
    @(negedge clk);
    pkt_valid = 1'b0;
    // Loader stores word 0 at the next edge; read at the same edge.
    exp = model_q.pop_front();
    bus_rd_en = 1'b1;
    #1 d = bus_rd_data;
    @(negedge clk);
    bus_rd_en = 1'b0;
    chk("R9 data", d, exp);
    chk("R9 level held", 32'(level), 32'd4);
    repeat (3) @(negedge clk);
    chk("R9 level final", 32'(level), 32'd7);
    model_q.push_back(32'hB0); model_q.push_back(32'hB1);
    model_q.push_back(32'hB2); model_q.push_back(32'hB3);
    for (int i = 0; i < 7; i++) read_expect("R9 order");
  endtask

  task automatic t_fill_boundary();
    for (int p = 0; p < DEPTH / 4; p++)
      send_pkt({16'hF000 | 16'(p), 16'h0}, {16'hF000 | 16'(p), 16'h1},
               {16'hF000 | 16'(p), 16'h2}, {16'hF000 | 16'(p), 16'h3}, 1, 0, "R10 fill");
    chk("R10 full level", 32'(level), 32'(DEPTH));
    chk("R4 no ovf yet", 32'(err_overflow), 32'd0);
    send_pkt(32'hDEAD_0000, 32'hDEAD_0001, 32'hDEAD_0002, 32'hDEAD_0003, 0, 0, "R4 zero free");
    read_expect("R6 pop at full");
    send_pkt(32'hDEAD_0010, 32'hDEAD_0011, 32'hDEAD_0012, 32'hDEAD_0013, 0, 0, "R4 one free");
    for (int i = 0; i < 3; i++) read_expect("R6 pop");
    send_pkt(32'hBEEF_0000, 32'hBEEF_0001, 32'hBEEF_0002, 32'hBEEF_0003, 1, 1, "R10 four free");
    chk("R10 refull", 32'(level), 32'(DEPTH));
    while (model_q.size() > 0) read_expect("R10 wrap drain");
    chk("R5 ovf sticky", 32'(err_overflow), 32'd1);
    send_pkt(32'h5, 32'h6, 32'h7, 32'h8, 1, 0, "R5 later accept");
    chk("R5 ovf still", 32'(err_overflow), 32'd1);
    for (int i = 0; i < 4; i++) read_expect("R2 after wrap");
    read_expect("R7 empty again");
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_single_packet();
    t_bus_write();
    t_same_cycle();
    t_fill_boundary();
    do_reset();
    chk("R1 R5 ovf cleared", 32'(err_overflow), 32'd0);
    chk("R1 R8 wrerr cleared", 32'(err_bus_write), 32'd0);
    chk("R1 level cleared", 32'(level), 32'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule